// File: doc/BRIEF.md
# Flags Register Interrupt Controller

This block holds the processor's 32-bit flags register and turns its bits into control actions for the core. Software writes the register through a plain write strobe. Three hardware event pulses set sticky status bits: a periodic timer tick, a UART transmit-ready event and a UART receive-data event. The block raises a permanent halt. It also issues two kinds of stack-sequencing actions on a valid/ready channel. One is an interrupt entry: the core moves SP down by the word size, stores the current PC at the new SP and jumps to the vector supplied. The other is an interrupt return: the core loads PC from the word at SP and moves SP up by the word size.

The action channel follows valid/ready rules. Once `act_valid` is high it stays high, and `act_kind` and `act_vector` stay unchanged, until the core accepts the action with `act_ready` at a rising edge. The flag side effects of the action (interrupt enable cleared on entry; enable set and the return bit cleared on return) happen at that same accepting edge. No new action starts in the cycle that follows an acceptance. The core may hold `act_ready` high at all times.

Bit map: 0 halt, 1 global interrupt enable, 2 return request, 3/4 timer enable/asserted, 5/6 transmit enable/asserted, 7/8 receive enable/asserted, 9 transmit ready, 10 receive data available, 11–31 reserved.

Top module: `fr_irq_ctrl`

## Requirements
- R1: After reset the register reads 0x200, `halt` is 0 and `act_valid` is 0.
- R2: Bits 11–31 always read 0. A write loads bits 1, 2, 3, 5 and 7 directly from the write data.
- R3: Bits 4, 6, 8, 9 and 10 are set only by hardware events. A software write can clear them by writing 0, and writing 1 leaves them unchanged.
- R4: When a hardware set and a software clear of the same bit fall in one cycle, the bit ends up set.
- R5: A timer event sets bit 4. A transmit event sets bits 6 and 9. A receive event sets bits 8 and 10.
- R6: No entry action is issued while bit 1 is 0, and none is issued for a source whose enable bit is 0.
- R7: An entry is launched only in a cycle where `insn_boundary` is 1, bit 1 is 1 and some source has both its asserted bit and its enable bit set. `act_valid` rises at the next edge with `act_kind`=0. The vector is VEC_BASE + index×VEC_STRIDE, where the index is timer 0, receive 1, transmit 2.
- R8: When several sources are eligible, the timer wins over receive, and receive wins over transmit.
- R9: While `act_valid` is high and `act_ready` is low, the action stays unchanged. Accepting an entry clears bit 1.
- R10: When bit 2 is set, a return action (`act_kind`=1) is issued without waiting for an instruction boundary. Accepting it sets bit 1 and clears bit 2.
- R11: Writing 1 to bit 0 raises `halt`. It stays high until reset, whatever is written later, and no action is issued while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fr_wr_en | input | 1 | Software write strobe for the flags register |
| fr_wr_data | input | 32 | Software write value |
| fr_q | output | 32 | Current flags register value |
| evt_timer | input | 1 | Timer tick pulse |
| evt_tx_ready | input | 1 | UART transmit-ready pulse |
| evt_rx_data | input | 1 | UART receive-data pulse |
| insn_boundary | input | 1 | High when the core sits between instructions |
| halt | output | 1 | Processor halted |
| act_valid | output | 1 | Stack action pending |
| act_ready | input | 1 | Core accepts the pending action |
| act_kind | output | 1 | 0 = interrupt entry, 1 = interrupt return |
| act_vector | output | 32 | Entry target address (0 for return) |

## Verification
The assertions assume that the core issues no flags-register write while an action is pending. They also assume that a halt write comes from an executing instruction, so it never lands on the same edge as an action launch. The bench keeps `fr_wr_en` low whenever `act_valid` may be high. It also keeps `insn_boundary` low during every register write, so each launch decision sees a settled register value.

// File: rtl/fr_irq_pkg.sv
package fr_irq_pkg;
  localparam int FR_W   = 32;
  localparam int NSRC   = 3;

  localparam int B_HALT   = 0;
  localparam int B_GIE    = 1;
  localparam int B_RET    = 2;
  localparam int B_TMR_EN = 3;
  localparam int B_TMR_AS = 4;
  localparam int B_TX_EN  = 5;
  localparam int B_TX_AS  = 6;
  localparam int B_RX_EN  = 7;
  localparam int B_RX_AS  = 8;
  localparam int B_TX_RDY = 9;
  localparam int B_RX_RDY = 10;
  localparam int B_TOP    = 10;

  localparam logic [FR_W-1:0] RESET_VAL = FR_W'(1) << B_TX_RDY;
  localparam logic [FR_W-1:0] SW_MASK =
    (FR_W'(1) << B_GIE) | (FR_W'(1) << B_RET) | (FR_W'(1) << B_TMR_EN) |
    (FR_W'(1) << B_TX_EN) | (FR_W'(1) << B_RX_EN);
  localparam logic [FR_W-1:0] STICKY_MASK =
    (FR_W'(1) << B_TMR_AS) | (FR_W'(1) << B_TX_AS) | (FR_W'(1) << B_RX_AS) |
    (FR_W'(1) << B_TX_RDY) | (FR_W'(1) << B_RX_RDY);

  // source index doubles as priority rank: lower index wins
  localparam int SRC_TMR = 0;
  localparam int SRC_RX  = 1;
  localparam int SRC_TX  = 2;

  typedef enum logic {ACT_ENTER = 1'b0, ACT_RETURN = 1'b1} act_kind_e;

  function automatic int enable_bit(input int src);
    case (src)
      SRC_TMR: return B_TMR_EN;
      SRC_RX:  return B_RX_EN;
      default: return B_TX_EN;
    endcase
  endfunction

  function automatic int asserted_bit(input int src);
    case (src)
      SRC_TMR: return B_TMR_AS;
      SRC_RX:  return B_RX_AS;
      default: return B_TX_AS;
    endcase
  endfunction
endpackage

// File: rtl/fr_flags.sv
module fr_flags
  import fr_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [FR_W-1:0] wr_data,
  input  logic [FR_W-1:0] hw_set,
  input  logic            ent_ack,
  input  logic            ret_ack,
  output logic [FR_W-1:0] fr_q
);
  logic [FR_W-1:0] nxt;

  always_comb begin
    nxt = fr_q;
    if (wr_en) begin
      nxt = (nxt & ~SW_MASK) | (wr_data & SW_MASK);
      nxt = nxt & (wr_data | ~STICKY_MASK);
      nxt[B_HALT] = fr_q[B_HALT] | wr_data[B_HALT];
    end
    if (ent_ack) nxt[B_GIE] = 1'b0;
    if (ret_ack) begin
      nxt[B_GIE] = 1'b1;
      nxt[B_RET] = 1'b0;
    end
    nxt = nxt | (hw_set & STICKY_MASK);
    nxt[FR_W-1:B_TOP+1] = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) fr_q <= RESET_VAL;
    else        fr_q <= nxt;
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fr_q[FR_W-1:B_TOP+1] == '0);
  assert_sticky_hw_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fr_q[B_TMR_AS]) |-> $past(hw_set[B_TMR_AS]));
  assert_hw_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hw_set[B_RX_AS] |=> fr_q[B_RX_AS]);
  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    fr_q[B_HALT] |=> fr_q[B_HALT]);
endmodule

// File: rtl/fr_arbiter.sv
module fr_arbiter
  import fr_irq_pkg::*;
#(
  parameter int              N_SRC      = NSRC,
  parameter logic [FR_W-1:0] VEC_BASE   = 32'h0000_0100,
  parameter logic [FR_W-1:0] VEC_STRIDE = 32'h0000_0010
)(
  input  logic [N_SRC-1:0] src_en,
  input  logic [N_SRC-1:0] src_as,
  output logic             any_req,
  output logic [FR_W-1:0]  vector
);
  logic [N_SRC-1:0] req;
  int sel;

  for (genvar g = 0; g < N_SRC; g++) begin : g_req
    assign req[g] = src_en[g] & src_as[g];
  end

  always_comb begin
    sel = 0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (req[i]) sel = i;
    end
  end

  assign any_req = |req;
  assign vector  = VEC_BASE + FR_W'(sel) * VEC_STRIDE;

  always_comb begin
    if (req[0]) assert_top_priority_R8: assert (vector == VEC_BASE);
  end
endmodule

// File: rtl/fr_act_seq.sv
module fr_act_seq
  import fr_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            halted,
  input  logic            ret_req,
  input  logic            gie,
  input  logic            boundary,
  input  logic            any_req,
  input  logic [FR_W-1:0] win_vector,
  input  logic            act_ready,
  output logic            act_valid,
  output act_kind_e       act_kind,
  output logic [FR_W-1:0] act_vector,
  output logic            ent_ack,
  output logic            ret_ack
);
  logic launch_ret, launch_ent;

  assign launch_ret = !act_valid && !halted && ret_req;
  assign launch_ent = !act_valid && !halted && !ret_req && boundary && gie && any_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_valid  <= 1'b0;
      act_kind   <= ACT_ENTER;
      act_vector <= '0;
    end else if (act_valid) begin
      if (act_ready) act_valid <= 1'b0;
    end else if (launch_ret) begin
      act_valid  <= 1'b1;
      act_kind   <= ACT_RETURN;
      act_vector <= '0;
    end else if (launch_ent) begin
      act_valid  <= 1'b1;
      act_kind   <= ACT_ENTER;
      act_vector <= win_vector;
    end
  end

  assign ent_ack = act_valid && act_ready && (act_kind == ACT_ENTER);
  assign ret_ack = act_valid && act_ready && (act_kind == ACT_RETURN);

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && !act_ready |=> act_valid && $stable(act_kind) && $stable(act_vector));
  assert_no_launch_halted_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !act_valid |=> !act_valid);
  assert_enter_needs_gie_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_valid && !gie && !ret_req |=> !act_valid);
endmodule

// File: rtl/fr_irq_ctrl.sv
module fr_irq_ctrl
  import fr_irq_pkg::*;
#(
  parameter logic [FR_W-1:0] VEC_BASE   = 32'h0000_0100,
  parameter logic [FR_W-1:0] VEC_STRIDE = 32'h0000_0010
)(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fr_wr_en,
  input  logic [FR_W-1:0] fr_wr_data,
  output logic [FR_W-1:0] fr_q,
  input  logic            evt_timer,
  input  logic            evt_tx_ready,
  input  logic            evt_rx_data,
  input  logic            insn_boundary,
  output logic            halt,
  output logic            act_valid,
  input  logic            act_ready,
  output logic            act_kind,
  output logic [FR_W-1:0] act_vector
);
  logic [FR_W-1:0] hw_set;
  logic [NSRC-1:0] src_en, src_as;
  logic            any_req, ent_ack, ret_ack;
  logic [FR_W-1:0] win_vector;
  act_kind_e       kind_q;

  always_comb begin
    hw_set = '0;
    hw_set[B_TMR_AS] = evt_timer;
    hw_set[B_TX_AS]  = evt_tx_ready;
    hw_set[B_TX_RDY] = evt_tx_ready;
    hw_set[B_RX_AS]  = evt_rx_data;
    hw_set[B_RX_RDY] = evt_rx_data;
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src
    assign src_en[s] = fr_q[enable_bit(s)];
    assign src_as[s] = fr_q[asserted_bit(s)];
  end

  fr_flags u_flags (
    .clk(clk), .rst_n(rst_n), .wr_en(fr_wr_en), .wr_data(fr_wr_data),
    .hw_set(hw_set), .ent_ack(ent_ack), .ret_ack(ret_ack), .fr_q(fr_q)
  );

  fr_arbiter #(.N_SRC(NSRC), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)) u_arb (
    .src_en(src_en), .src_as(src_as), .any_req(any_req), .vector(win_vector)
  );

  fr_act_seq u_seq (
    .clk(clk), .rst_n(rst_n), .halted(fr_q[B_HALT]), .ret_req(fr_q[B_RET]),
    .gie(fr_q[B_GIE]), .boundary(insn_boundary), .any_req(any_req),
    .win_vector(win_vector), .act_ready(act_ready), .act_valid(act_valid),
    .act_kind(kind_q), .act_vector(act_vector), .ent_ack(ent_ack), .ret_ack(ret_ack)
  );

  assign act_kind = kind_q;
  assign halt     = fr_q[B_HALT];

  assert_entry_clears_gie_R9: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_ready && !act_kind |=> !fr_q[B_GIE]);
  assert_return_effects_R10: assert property (@(posedge clk) disable iff (!rst_n)
    act_valid && act_ready && act_kind |=> fr_q[B_GIE] && !fr_q[B_RET]);
  assert_event_map_R5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_tx_ready |=> fr_q[B_TX_AS] && fr_q[B_TX_RDY]);
endmodule

// File: tb/fr_irq_ctrl_tb.sv
module fr_irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fr_wr_en = 1'b0;
  logic [31:0] fr_wr_data = '0;
  logic [31:0] fr_q;
  logic        evt_timer = 1'b0, evt_tx_ready = 1'b0, evt_rx_data = 1'b0;
  logic        insn_boundary = 1'b0;
  logic        halt, act_valid, act_kind;
  logic        act_ready = 1'b0;
  logic [31:0] act_vector;
  int n_checks = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  fr_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .fr_wr_en(fr_wr_en), .fr_wr_data(fr_wr_data),
    .fr_q(fr_q), .evt_timer(evt_timer), .evt_tx_ready(evt_tx_ready),
    .evt_rx_data(evt_rx_data), .insn_boundary(insn_boundary), .halt(halt),
    .act_valid(act_valid), .act_ready(act_ready), .act_kind(act_kind),
    .act_vector(act_vector)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] d);
    @(negedge clk); fr_wr_en = 1'b1; fr_wr_data = d;
    @(negedge clk); fr_wr_en = 1'b0;
  endtask

  task automatic pulse(input logic t, input logic tx, input logic rx);
    @(negedge clk); evt_timer = t; evt_tx_ready = tx; evt_rx_data = rx;
    @(negedge clk); evt_timer = 1'b0; evt_tx_ready = 1'b0; evt_rx_data = 1'b0;
  endtask

  // boundary high for n cycles with no acceptance; act_valid must stay low
  task automatic idle_boundary(input string req, input int n);
    @(negedge clk); insn_boundary = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); chk(req, {31'd0, act_valid}, 32'd0);
    end
    insn_boundary = 1'b0;
  endtask

  task automatic take(input string req, input logic [31:0] vec, input logic [31:0] fr_after);
    @(negedge clk); insn_boundary = 1'b1;
    @(negedge clk); insn_boundary = 1'b0;
    chk({req, " valid"}, {31'd0, act_valid}, 32'd1);
    chk({req, " kind"}, {31'd0, act_kind}, 32'd0);
    chk({req, " vector"}, act_vector, vec);
    @(negedge clk); act_ready = 1'b1;
    @(negedge clk); act_ready = 1'b0;
    chk({req, " drop"}, {31'd0, act_valid}, 32'd0);
    chk({req, " fr"}, fr_q, fr_after);
  endtask

  task automatic t_reset();
    chk("R1 fr", fr_q, 32'h200);
    chk("R1 halt", {31'd0, halt}, 32'd0);
    chk("R1 valid", {31'd0, act_valid}, 32'd0);
  endtask

  task automatic t_write_mask();
    wr(32'hFFFF_FFA8); chk("R2 mask", fr_q, 32'h2A8);
    wr(32'h0);         chk("R3 clear", fr_q, 32'h0);
    wr(32'hFFFF_FFFA); chk("R3 no sw set", fr_q, 32'h0AA);
    wr(32'h0);
  endtask

  task automatic t_event_map();
    pulse(0, 1, 0); chk("R5 tx", fr_q, 32'h240);
    pulse(0, 0, 1); chk("R5 rx", fr_q, 32'h740);
    pulse(1, 0, 0); chk("R5 timer", fr_q, 32'h750);
    wr(32'h0);
  endtask

  task automatic t_hw_wins();
    pulse(0, 0, 1);
    @(negedge clk); fr_wr_en = 1'b1; fr_wr_data = 32'h0; evt_rx_data = 1'b1;
    @(negedge clk); fr_wr_en = 1'b0; evt_rx_data = 1'b0;
    chk("R4 hw wins", fr_q, 32'h500);
    wr(32'h0);
  endtask

  task automatic t_gating();
    pulse(1, 0, 0);
    wr(32'h18); idle_boundary("R6 gie off", 3);
    wr(32'h12); idle_boundary("R6 enable off", 3);
    wr(32'h1A);
    repeat (3) begin
      @(negedge clk); chk("R7 no boundary", {31'd0, act_valid}, 32'd0);
    end
  endtask

  task automatic t_take_hold();
    @(negedge clk); insn_boundary = 1'b1;
    @(negedge clk); insn_boundary = 1'b0;
    chk("R7 launch", {31'd0, act_valid}, 32'd1);
    chk("R7 vector timer", act_vector, 32'h100);
    repeat (2) begin
      @(negedge clk);
      chk("R9 hold valid", {31'd0, act_valid}, 32'd1);
      chk("R9 hold vector", act_vector, 32'h100);
    end
    @(negedge clk); act_ready = 1'b1;
    @(negedge clk); act_ready = 1'b0;
    chk("R9 gie cleared", fr_q, 32'h18);
    wr(32'h0);
  endtask

  task automatic t_priority();
    pulse(1, 1, 1); chk("R8 flags", fr_q, 32'h750);
    wr(32'h7FA); take("R8 timer first", 32'h100, 32'h7F8);
    wr(32'h7EA); take("R8 rx second", 32'h110, 32'h7E8);
    wr(32'h2EA); take("R8 tx last", 32'h120, 32'h2E8);
  endtask

  task automatic t_return();
    wr(32'h2EC);
    @(negedge clk);
    chk("R10 valid", {31'd0, act_valid}, 32'd1);
    chk("R10 kind", {31'd0, act_kind}, 32'd1);
    @(negedge clk); act_ready = 1'b1;
    @(negedge clk); act_ready = 1'b0;
    chk("R10 fr", fr_q, 32'h2EA);
    chk("R10 drop", {31'd0, act_valid}, 32'd0);
    wr(32'h0);
  endtask

  task automatic t_halt();
    wr(32'h1); chk("R11 halt", {31'd0, halt}, 32'd1);
    wr(32'h0); chk("R11 sticky", fr_q, 32'h1);
    pulse(1, 0, 0);
    wr(32'h1A); chk("R11 fr", fr_q, 32'h1B);
    idle_boundary("R11 no entry", 3);
    wr(32'h1E);
    idle_boundary("R11 no return", 3);
    chk("R11 still halted", {31'd0, halt}, 32'd1);
  endtask

  initial begin
    fork
      begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_mask();
        t_event_map();
        t_hw_wins();
        t_gating();
        t_take_hold();
        t_priority();
        t_return();
        t_halt();
      end
      begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule